// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. Bits are gathered into 4-bit groups. Each group forms a generate and a propagate term for every bit, and works out its three inner carries from closed-form lookahead equations. It also sums its bits and reports one generate and one propagate term for the whole group. A second lookahead level, of the same shape, takes the four group terms and the carry-in and gives the carry into each group. It also gives a generate/propagate pair for each 16-bit block. Wider adders are built by chaining 16-bit blocks through that block-level carry.

The width is a parameter: 16 bits by default, and any multiple of 16 (32 in common use). A second parameter picks how the bit propagate term is formed: the OR or the XOR of the two operand bits. The carries and the sum are the same under either choice. Only the exported group propagate flags differ. The per-group generate and propagate flags are brought out so that a larger structure can cascade from them.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals (a + b + cin) modulo 2^WIDTH for every operand pair and both values of `cin`.
- R2: `cout` equals bit WIDTH of the full-precision value a + b + cin.
- R3: `grp_gen[k]` is 1 exactly when the 4-bit slice a[4k+3:4k] plus the slice b[4k+3:4k] exceeds 15. It does not depend on `cin`.
- R4: `grp_prop[k]` depends on PMODE. When PMODE is PROP_OR (encoding 0), it is 1 exactly when every bit of the OR of the two slices is 1. When PMODE is PROP_XOR (encoding 1), it is 1 exactly when the XOR of the two slices is 4'hF.
- R5: A carry entering at bit 0 reaches `cout` through every group. All-ones plus zero with `cin`=1 gives `sum`=0 and `cout`=1, and so does all-ones plus one with `cin`=0.
- R6: A 32-bit adder made of two cascaded 16-bit blocks matches a behavioural adder on random and directed operands, including carries that cross the block boundary.
- R7: For equal inputs, `sum` and `cout` are identical whichever PMODE is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |
| grp_gen | output | WIDTH/4 | Generate flag of each 4-bit group |
| grp_prop | output | WIDTH/4 | Propagate flag of each 4-bit group |

## Verification
The hardest case to reach is a carry that must travel through every group and across the 16-bit block boundary. For that, each group has to propagate while none generates, and uniform random operands almost never produce it. The stimulus therefore adds directed vectors: all ones plus a carry-in, complementary patterns such as 0x5555 plus 0xAAAA, and slices that all sum to exactly 15. It also adds slices where both operands are all ones. There the OR and XOR propagate forms disagree, which separates the two modes' group flags while their sums must still agree.

// File: rtl/cla_pkg.sv
package cla_pkg;

    localparam int GRP_W = 4;
    localparam int BLK_W = 16;

    typedef enum logic {
        PROP_OR  = 1'b0,
        PROP_XOR = 1'b1
    } prop_mode_e;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Carries c1..c4 of a 4-wide lookahead, each from g, p and ci only
    function automatic logic [4:1] la_carries(input logic [3:0] g,
                                              input logic [3:0] p,
                                              input logic       ci);
        logic [4:1] c;
        c[1] = g[0] | (p[0] & ci);
        c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & ci);
        c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
                    | (p[2] & p[1] & p[0] & ci);
        c[4] = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                    | (p[3] & p[2] & p[1] & g[0])
                    | (p[3] & p[2] & p[1] & p[0] & ci);
        return c;
    endfunction

    // Combined generate / propagate of four adjacent positions
    function automatic gp_t la_combine(input logic [3:0] g,
                                       input logic [3:0] p);
        gp_t r;
        r.g = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
                   | (p[3] & p[2] & p[1] & g[0]);
        r.p = &p;
        return r;
    endfunction

endpackage

// File: rtl/cla_group4.sv
module cla_group4
    import cla_pkg::*;
#(
    parameter prop_mode_e PMODE = PROP_OR
) (
    input  logic [GRP_W-1:0] x,
    input  logic [GRP_W-1:0] y,
    input  logic             ci,
    output logic [GRP_W-1:0] s,
    output gp_t              grp
);
    logic [GRP_W-1:0] bit_g;
    logic [GRP_W-1:0] bit_p;
    logic [4:1]       cy;

    assign bit_g = x & y;

    generate
        if (PMODE == PROP_XOR) begin : g_pxor
            assign bit_p = x ^ y;
        end else begin : g_por
            assign bit_p = x | y;
        end
    endgenerate

    assign cy  = la_carries(bit_g, bit_p, ci);
    assign s   = x ^ y ^ {cy[3:1], ci};
    assign grp = la_combine(bit_g, bit_p);

    always_comb begin
        // R1
        grp_sum_chk: assert ({cy[4], s} == ({1'b0, x} + {1'b0, y} + {4'b0, ci}))
            else $error("group sum mismatch");
        // R5
        grp_carry_chk: assert (cy[4] == (grp.g | (grp.p & ci)))
            else $error("group carry disagrees with group terms");
    end
endmodule

// File: rtl/cla_lookahead4.sv
module cla_lookahead4
    import cla_pkg::*;
(
    input  gp_t [3:0] grp,
    input  logic      ci,
    output logic [4:1] cy,
    output gp_t       blk
);
    logic [3:0] gg;
    logic [3:0] gpv;

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            gg[i]  = grp[i].g;
            gpv[i] = grp[i].p;
        end
    end

    assign cy  = la_carries(gg, gpv, ci);
    assign blk = la_combine(gg, gpv);

    always_comb begin
        // R5
        la_carry_chk: assert (cy[4] == (blk.g | (blk.p & ci)))
            else $error("second-level carry disagrees with block terms");
    end
endmodule

// File: rtl/cla_block16.sv
module cla_block16
    import cla_pkg::*;
#(
    parameter prop_mode_e PMODE = PROP_OR
) (
    input  logic [BLK_W-1:0] x,
    input  logic [BLK_W-1:0] y,
    input  logic             ci,
    output logic [BLK_W-1:0] s,
    output gp_t [3:0]        grp,
    output gp_t              blk
);
    localparam int NG = BLK_W / GRP_W;

    logic [4:1]  cy;
    logic [NG:0] gci;

    assign gci = {cy, ci};

    for (genvar k = 0; k < NG; k++) begin : g_grp
        cla_group4 #(.PMODE(PMODE)) u_grp (
            .x  (x[k*GRP_W +: GRP_W]),
            .y  (y[k*GRP_W +: GRP_W]),
            .ci (gci[k]),
            .s  (s[k*GRP_W +: GRP_W]),
            .grp(grp[k])
        );
    end

    cla_lookahead4 u_la (
        .grp(grp),
        .ci (ci),
        .cy (cy),
        .blk(blk)
    );
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int         WIDTH = 16,
    parameter prop_mode_e PMODE = PROP_OR
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               cin,
    output logic [WIDTH-1:0]   sum,
    output logic               cout,
    output logic [WIDTH/4-1:0] grp_gen,
    output logic [WIDTH/4-1:0] grp_prop
);
    localparam int NBLK = WIDTH / BLK_W;
    localparam int GPB  = BLK_W / GRP_W;

    logic [NBLK:0] bcy;
    gp_t  [NBLK-1:0] blk;

    assign bcy[0] = cin;

    for (genvar k = 0; k < NBLK; k++) begin : g_blk
        gp_t [3:0] grp;

        cla_block16 #(.PMODE(PMODE)) u_blk (
            .x  (a[k*BLK_W +: BLK_W]),
            .y  (b[k*BLK_W +: BLK_W]),
            .ci (bcy[k]),
            .s  (sum[k*BLK_W +: BLK_W]),
            .grp(grp),
            .blk(blk[k])
        );

        // Block-level carry to the next 16-bit unit
        assign bcy[k+1] = blk[k].g | (blk[k].p & bcy[k]);

        for (genvar j = 0; j < GPB; j++) begin : g_out
            assign grp_gen[k*GPB + j]  = grp[j].g;
            assign grp_prop[k*GPB + j] = grp[j].p;
        end
    end

    assign cout = bcy[NBLK];

    always_comb begin
        // R1 R2 R6
        total_sum_chk: assert ({cout, sum} ==
                ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("adder total mismatch");
    end
endmodule

// File: tb/cla_adder_tb.sv
`timescale 1ns/1ps
module cla_adder_tb;
    import cla_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [31:0] a, b;
    logic        cin;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;

    logic [15:0] s16o, s16x;
    logic [31:0] s32o, s32x;
    logic        c16o, c16x, c32o, c32x;
    logic [3:0]  gg16o, gp16o, gg16x, gp16x;
    logic [7:0]  gg32o, gp32o, gg32x, gp32x;

    cla_adder #(.WIDTH(16), .PMODE(PROP_OR)) u_dut (
        .a(a[15:0]), .b(b[15:0]), .cin(cin), .sum(s16o), .cout(c16o),
        .grp_gen(gg16o), .grp_prop(gp16o));
    cla_adder #(.WIDTH(16), .PMODE(PROP_XOR)) u_dut16x (
        .a(a[15:0]), .b(b[15:0]), .cin(cin), .sum(s16x), .cout(c16x),
        .grp_gen(gg16x), .grp_prop(gp16x));
    cla_adder #(.WIDTH(32), .PMODE(PROP_OR)) u_dut32o (
        .a(a), .b(b), .cin(cin), .sum(s32o), .cout(c32o),
        .grp_gen(gg32o), .grp_prop(gp32o));
    cla_adder #(.WIDTH(32), .PMODE(PROP_XOR)) u_dut32x (
        .a(a), .b(b), .cin(cin), .sum(s32x), .cout(c32x),
        .grp_gen(gg32x), .grp_prop(gp32x));

    task automatic chk(input string tag, input longint unsigned act,
                       input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%0d)",
                     tag, act, exp, a, b, cin);
        end
    endtask

    task automatic check_one(input int w, input bit xmode, input string nm,
                             input longint unsigned s_act, input bit c_act,
                             input longint unsigned gg_act,
                             input longint unsigned gp_act);
        longint unsigned m   = (64'd1 << w) - 1;
        longint unsigned tot = (longint'(a) & m) + (longint'(b) & m) + longint'(cin);
        longint unsigned eg  = 0;
        longint unsigned ep  = 0;
        for (int k = 0; k < w / 4; k++) begin
            int an = int'((a >> (4 * k)) & 32'hF);
            int bn = int'((b >> (4 * k)) & 32'hF);
            if (an + bn > 15) eg |= (64'd1 << k);
            if (xmode ? ((an ^ bn) == 15) : ((an | bn) == 15)) ep |= (64'd1 << k);
        end
        chk({"R1 sum ", nm}, s_act, tot & m);
        chk({"R2 cout ", nm}, longint'(c_act), (tot >> w) & 1);
        chk({"R3 grp_gen ", nm}, gg_act, eg);
        chk({"R4 grp_prop ", nm}, gp_act, ep);
        if (w == 32) chk({"R6 cascade ", nm}, {31'b0, c_act, s_act[31:0]}, tot);
    endtask

    task automatic apply(input logic [31:0] va, input logic [31:0] vb,
                         input logic vc);
        @(posedge clk);
        #1;
        a = va; b = vb; cin = vc;
        @(negedge clk);
        check_one(16, 1'b0, "w16/or",  longint'(s16o), c16o, longint'(gg16o), longint'(gp16o));
        check_one(16, 1'b1, "w16/xor", longint'(s16x), c16x, longint'(gg16x), longint'(gp16x));
        check_one(32, 1'b0, "w32/or",  longint'(s32o), c32o, longint'(gg32o), longint'(gp32o));
        check_one(32, 1'b1, "w32/xor", longint'(s32x), c32x, longint'(gg32x), longint'(gp32x));
        // R7: propagate form has no effect on the sum
        chk("R7 mode-independent sum16", {47'b0, c16o, s16o}, {47'b0, c16x, s16x});
        chk("R7 mode-independent sum32", {31'b0, c32o, s32o}, {31'b0, c32x, s32x});
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        // zero inputs: idle state
        apply(32'h0, 32'h0, 1'b0);
        // R5: full carry chain, both ways of producing it
        apply(32'hFFFF_FFFF, 32'h0, 1'b1);
        apply(32'hFFFF_FFFF, 32'h1, 1'b0);
        apply(32'h0000_FFFF, 32'h0, 1'b1);
        // R5 all propagate, no generate
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
        apply(32'h1234_5678, 32'hEDCB_A987, 1'b1);
        // R4 OR and XOR propagate disagree
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        apply(32'hF0F0_F0F0, 32'hFF0F_F00F, 1'b1);
        // R6 carry crosses block boundary only
        apply(32'h0000_8000, 32'h0000_8000, 1'b0);
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            if (i % 7 == 0) rb = ~ra;
            apply(ra, rb, 1'($urandom));
        end
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule